// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises a periodic control task. While the watchdog is enabled, an internal cycle counter runs, and the task must service the watchdog once per control period. A service is a one-cycle kick strobe that carries a key word. It is accepted only if it lands inside a window. The window opens at a configurable count and closes at a configurable timeout count.

Three events are faults: a kick that arrives too early, a kick with the wrong key, and a period that passes with no valid kick. Each fault latches a fault flag and a safe-state request. The safe-state request forces the actuator path into a known condition. A configuration bit can also turn the fault into a reset request. A two-bit cause code records which check tripped.

The window and timeout counts, and the reset-request option, are set while the watchdog is disabled. They are locked while it runs. A latched fault can only be cleared by an explicit clear while disabled, or by the block reset. The supervised logic therefore cannot release the safe state by itself.

Top module: `win_watchdog`

## Requirements
- R1: After reset, fault, safe_state and reset_req are 0, cause is 00, and the window-open and timeout counts take their parameter defaults with the reset-request option off.
- R2: While enabled and not faulted, the counter increments by one per clock. A kick with the correct key when open <= count < timeout restarts the count at zero and raises no fault. Both edges of the window, count = open and count = timeout-1, are accepted.
- R3: If the count reaches the timeout value without a valid kick, the fault latches with cause 01. Counting from a restart at zero with no kick, fault is first seen after timeout+1 clock edges. A correctly keyed kick at count >= timeout is also cause 01.
- R4: A correctly keyed kick while count < open latches the fault with cause 10.
- R5: A kick whose key differs from the KEY parameter (0xC35A by default) latches the fault with cause 11. This check takes priority over the early and late checks.
- R6: The cause code is 00 exactly when no fault is latched. When a fault is latched, the code is 01 (late or missing), 10 (early) or 11 (bad key).
- R7: A latched fault and its cause hold until fault_clr is asserted while enable is low. fault_clr while enabled has no effect.
- R8: cfg_we loads cfg_open, cfg_limit and cfg_rst_en only while enable is low. Writes while enabled are ignored.
- R9: safe_state equals the fault flag. reset_req equals the fault flag ANDed with the stored reset-request option.
- R10: While disabled, the counter is held at zero and kicks are ignored. After enabling, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Watchdog running when high |
| cfg_we | input | 1 | Configuration write strobe (effective only when disabled) |
| cfg_open | input | CNT_W | Count at which the service window opens |
| cfg_limit | input | CNT_W | Timeout count, where the window closes |
| cfg_rst_en | input | 1 | Reset-request option for faults |
| kick | input | 1 | Service strobe |
| kick_key | input | KEY_W | Key word carried by the service strobe |
| fault_clr | input | 1 | Clears a latched fault (effective only when disabled) |
| fault | output | 1 | Latched fault flag |
| safe_state | output | 1 | Request to force the actuator path to its safe condition |
| reset_req | output | 1 | Hardware reset request |
| cause | output | 2 | Fault cause code |

## Verification
The bench probes both window edges: count = open, count = timeout-1, count = open-1 and count = timeout. A design with an off-by-one comparison there would either reject a legal service or accept one that a too-fast or too-slow loop produced. Bad keys are sent inside the window, before it and at the timeout count. A design with the wrong priority would report early or late instead of the key fault. The bench tries to change the configuration while running and then kicks at a count that is only legal under the new values. If the lock leaked, that kick would go unpunished. It also tries a clear while enabled, which must leave the fault latched, and re-enables after a pause, which exposes a counter that fails to restart from zero.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_LATE  = 2'b01,
        CAUSE_EARLY = 2'b10,
        CAUSE_KEY   = 2'b11
    } cause_e;

    // Outcome of evaluating one clock cycle against the service window
    typedef struct packed {
        logic   hit;      // a fault condition was detected this cycle
        logic   restart;  // a legal service restarts the count
        cause_e cause;    // which check tripped when hit is set
    } verdict_t;

endpackage

// File: rtl/wwd_cfg.sv
module wwd_cfg #(
    parameter int CNT_W     = 16,
    parameter int DEF_OPEN  = 100,
    parameter int DEF_LIMIT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_open,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic             cfg_rst_en,
    output logic [CNT_W-1:0] open_q,
    output logic [CNT_W-1:0] limit_q,
    output logic             rst_en_q
);

    typedef struct packed {
        logic [CNT_W-1:0] open;
        logic [CNT_W-1:0] limit;
        logic             rst_en;
    } cfg_t;

    localparam logic [CNT_W-1:0] OPEN_RST  = CNT_W'(DEF_OPEN);
    localparam logic [CNT_W-1:0] LIMIT_RST = CNT_W'(DEF_LIMIT);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        // configuration is locked while the watchdog runs
        if (cfg_we && !enable) begin
            cfg_d.open   = cfg_open;
            cfg_d.limit  = cfg_limit;
            cfg_d.rst_en = cfg_rst_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.open   <= OPEN_RST;
            cfg_q.limit  <= LIMIT_RST;
            cfg_q.rst_en <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign open_q   = cfg_q.open;
    assign limit_q  = cfg_q.limit;
    assign rst_en_q = cfg_q.rst_en;

endmodule

// File: rtl/wwd_judge.sv
module wwd_judge
    import wwd_pkg::*;
#(
    parameter int             CNT_W = 16,
    parameter int             KEY_W = 16,
    parameter logic [KEY_W-1:0] KEY = 16'hC35A
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] open_cnt,
    input  logic [CNT_W-1:0] limit_cnt,
    input  logic             kick,
    input  logic [KEY_W-1:0] kick_key,
    output verdict_t         verdict
);

    logic key_ok;
    logic too_late;
    logic too_early;

    assign key_ok    = (kick_key == KEY);
    assign too_late  = (cnt >= limit_cnt);
    assign too_early = (cnt <  open_cnt);

    always_comb begin
        verdict = '{hit: 1'b0, restart: 1'b0, cause: CAUSE_NONE};
        // priority: key check, then timeout, then early service
        if (kick && !key_ok) begin
            verdict.hit   = 1'b1;
            verdict.cause = CAUSE_KEY;
        end else if (too_late) begin
            verdict.hit   = 1'b1;
            verdict.cause = CAUSE_LATE;
        end else if (kick && too_early) begin
            verdict.hit   = 1'b1;
            verdict.cause = CAUSE_EARLY;
        end else if (kick) begin
            verdict.restart = 1'b1;
        end
    end

endmodule

// File: rtl/wwd_core.sv
module wwd_core
    import wwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fault_clr,
    input  verdict_t         verdict,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fault_q,
    output cause_e           cause_q
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
        cause_e           cause;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.cnt = '0;
            if (fault_clr) begin
                st_d.fault = 1'b0;
                st_d.cause = CAUSE_NONE;
            end
        end else if (!st_q.fault) begin
            if (verdict.hit) begin
                st_d.fault = 1'b1;
                st_d.cause = verdict.cause;
            end else if (verdict.restart) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_TOP) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.fault <= 1'b0;
            st_q.cause <= CAUSE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q   = st_q.cnt;
    assign fault_q = st_q.fault;
    assign cause_q = st_q.cause;

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wwd_pkg::*;
#(
    parameter int               CNT_W     = 16,
    parameter int               KEY_W     = 16,
    parameter logic [KEY_W-1:0] KEY       = 16'hC35A,
    parameter int               DEF_OPEN  = 100,
    parameter int               DEF_LIMIT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_open,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic             cfg_rst_en,
    input  logic             kick,
    input  logic [KEY_W-1:0] kick_key,
    input  logic             fault_clr,
    output logic             fault,
    output logic             safe_state,
    output logic             reset_req,
    output logic [1:0]       cause
);

    logic [CNT_W-1:0] open_q;
    logic [CNT_W-1:0] limit_q;
    logic             rst_en_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fault_q;
    cause_e           cause_q;
    verdict_t         verdict;

    wwd_cfg #(
        .CNT_W    (CNT_W),
        .DEF_OPEN (DEF_OPEN),
        .DEF_LIMIT(DEF_LIMIT)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cfg_we    (cfg_we),
        .cfg_open  (cfg_open),
        .cfg_limit (cfg_limit),
        .cfg_rst_en(cfg_rst_en),
        .open_q    (open_q),
        .limit_q   (limit_q),
        .rst_en_q  (rst_en_q)
    );

    wwd_judge #(
        .CNT_W(CNT_W),
        .KEY_W(KEY_W),
        .KEY  (KEY)
    ) u_judge (
        .cnt      (cnt_q),
        .open_cnt (open_q),
        .limit_cnt(limit_q),
        .kick     (kick),
        .kick_key (kick_key),
        .verdict  (verdict)
    );

    wwd_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .fault_clr(fault_clr),
        .verdict  (verdict),
        .cnt_q    (cnt_q),
        .fault_q  (fault_q),
        .cause_q  (cause_q)
    );

    assign fault      = fault_q;
    assign safe_state = fault_q;
    assign reset_req  = fault_q & rst_en_q;
    assign cause      = cause_q;

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
    parameter int               CNT_W = 16,
    parameter int               KEY_W = 16,
    parameter logic [KEY_W-1:0] KEY   = 16'hC35A
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             fault_clr,
    input logic             kick,
    input logic [KEY_W-1:0] kick_key,
    input logic             fault,
    input logic             safe_state,
    input logic             reset_req,
    input logic [1:0]       cause,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] open_q,
    input logic [CNT_W-1:0] limit_q
);

    logic armed;
    logic good_kick;
    logic bad_kick;

    assign armed     = enable && !fault;
    assign good_kick = kick && (kick_key == KEY);
    assign bad_kick  = kick && (kick_key != KEY);

    a_r1_clean_start: assert property (@(posedge clk)
        $rose(rst_n) |-> (!fault && !reset_req && cause == 2'b00));

    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && good_kick && cnt_q >= open_q && cnt_q < limit_q)
        |=> (cnt_q == '0 && !fault));

    a_r3_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !bad_kick && cnt_q >= limit_q) |=> (fault && cause == 2'b01));

    a_r4_early: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && good_kick && cnt_q < open_q && cnt_q < limit_q)
        |=> (fault && cause == 2'b10));

    a_r5_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bad_kick) |=> (fault && cause == 2'b11));

    a_r6_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
        fault == (cause != 2'b00));

    a_r7_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !(fault_clr && !enable)) |=> (fault && $stable(cause)));

    a_r8_cfg_lock: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(open_q) && $stable(limit_q)));

    a_r9_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req |-> fault) and (safe_state == fault));

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !fault_clr) |=> (cnt_q == '0 && $stable(fault)));

endmodule

bind win_watchdog wwd_checker #(
    .CNT_W(CNT_W),
    .KEY_W(KEY_W),
    .KEY  (KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .fault_clr (fault_clr),
    .kick      (kick),
    .kick_key  (kick_key),
    .fault     (fault),
    .safe_state(safe_state),
    .reset_req (reset_req),
    .cause     (cause),
    .cnt_q     (cnt_q),
    .open_q    (open_q),
    .limit_q   (limit_q)
);

// File: tb/win_watchdog_test.sv
module win_watchdog_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          CW         = 8;
    localparam int          KW         = 16;
    localparam logic [15:0] KEYV       = 16'hC35A;
    localparam logic [15:0] BADK       = 16'h1234;
    localparam int          OPEN0      = 4;
    localparam int          LIM0       = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_open = '0;
    logic [CW-1:0] cfg_limit = '0;
    logic          cfg_rst_en = 1'b0;
    logic          kick = 1'b0;
    logic [KW-1:0] kick_key = '0;
    logic          fault_clr = 1'b0;
    logic          fault;
    logic          safe_state;
    logic          reset_req;
    logic [1:0]    cause;

    win_watchdog #(
        .CNT_W(CW), .KEY_W(KW), .KEY(KEYV),
        .DEF_OPEN(OPEN0), .DEF_LIMIT(LIM0)
    ) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .cfg_open(cfg_open), .cfg_limit(cfg_limit), .cfg_rst_en(cfg_rst_en),
        .kick(kick), .kick_key(kick_key), .fault_clr(fault_clr),
        .fault(fault), .safe_state(safe_state), .reset_req(reset_req),
        .cause(cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    int    m_cnt = 0, m_open = OPEN0, m_lim = LIM0, m_rsten = 0;
    int    m_flt = 0, m_cause = 0;
    int    n_checks = 0, n_fails = 0;
    bit    done = 0;
    string cur = "R1";

    task automatic model_edge();
        if (!rst_n) begin
            m_cnt = 0; m_open = OPEN0; m_lim = LIM0; m_rsten = 0;
            m_flt = 0; m_cause = 0;
        end else if (!enable) begin
            m_cnt = 0;
            if (fault_clr) begin m_flt = 0; m_cause = 0; end
            if (cfg_we) begin
                m_open = int'(cfg_open); m_lim = int'(cfg_limit); m_rsten = int'(cfg_rst_en);
            end
        end else if (m_flt == 0) begin
            if (kick && kick_key != KEYV) begin m_flt = 1; m_cause = 3; end
            else if (m_cnt >= m_lim)      begin m_flt = 1; m_cause = 1; end
            else if (kick && m_cnt < m_open) begin m_flt = 1; m_cause = 2; end
            else if (kick)                m_cnt = 0;
            else if (m_cnt < 255)         m_cnt = m_cnt + 1;
        end
    endtask

    task automatic check(string tag, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        int got, exp;
        got = {fault, safe_state, reset_req, cause};
        exp = (m_flt << 4) | (m_flt << 3) | ((m_flt & m_rsten) << 2) | m_cause;
        check(cur, "fault/safe/rreq/cause", got, exp);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic run_to(int n);
        while (m_cnt != n && m_flt == 0) step();
    endtask

    task automatic kick_once(logic [KW-1:0] k);
        kick = 1'b1; kick_key = k;
        step();
        kick = 1'b0; kick_key = '0;
    endtask

    task automatic clear_fault();
        enable = 1'b0; fault_clr = 1'b1;
        step();
        fault_clr = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        cur = "R1";
        check("R1", "fault", int'(fault), 0);
        check("R1", "reset_req", int'(reset_req), 0);
        check("R1", "cause", int'(cause), 0);
        rst_n = 1'b1;
        step(); step();

        // R2: legal services, including both window edges
        cur = "R2";
        enable = 1'b1;
        for (int i = 0; i < 3; i++) begin run_to(5); kick_once(KEYV); end
        run_to(OPEN0);    kick_once(KEYV);
        run_to(LIM0 - 1); kick_once(KEYV);
        check("R2", "fault after legal kicks", int'(fault), 0);

        // R3: missing service
        cur = "R3";
        n = 0;
        while (!fault && n < 50) begin step(); n++; end
        check("R3", "edges to timeout", n, LIM0 + 1);
        check("R3", "cause", int'(cause), 1);
        check("R9", "safe_state", int'(safe_state), 1);
        check("R9", "reset_req with option off", int'(reset_req), 0);

        // R7: clear only while disabled
        cur = "R7";
        fault_clr = 1'b1; step(); fault_clr = 1'b0;
        check("R7", "clear while enabled ignored", int'(fault), 1);
        enable = 1'b0; step();
        check("R7", "fault held while disabled", int'(fault), 1);
        check("R7", "cause held", int'(cause), 1);
        clear_fault();
        check("R7", "fault cleared", int'(fault), 0);
        check("R6", "cause after clear", int'(cause), 0);

        // R8: writes while enabled ignored -> kick at 2 is still early
        cur = "R8";
        enable = 1'b1;
        cfg_we = 1'b1; cfg_open = 8'd1; cfg_limit = 8'd3; cfg_rst_en = 1'b1;
        step();
        cfg_we = 1'b0;
        run_to(2); kick_once(KEYV);
        check("R8", "cause with locked config", int'(cause), 2);
        check("R8", "reset option not loaded", int'(reset_req), 0);
        clear_fault();

        // R8 + R4 + R9: write while disabled, then early kick
        cur = "R4";
        cfg_we = 1'b1; cfg_open = 8'd2; cfg_limit = 8'd6; cfg_rst_en = 1'b1;
        step();
        cfg_we = 1'b0;
        enable = 1'b1;
        run_to(1); kick_once(KEYV);
        check("R4", "early cause", int'(cause), 2);
        check("R9", "reset_req with option on", int'(reset_req), 1);
        clear_fault();
        check("R9", "reset_req after clear", int'(reset_req), 0);

        // R2 edges under new config, then R3 late kick at timeout count
        cur = "R2";
        enable = 1'b1;
        run_to(2); kick_once(KEYV);
        run_to(5); kick_once(KEYV);
        check("R2", "edges of written window", int'(fault), 0);
        cur = "R3";
        run_to(6); kick_once(KEYV);
        check("R3", "kick at timeout is late", int'(cause), 1);
        clear_fault();

        // R5: bad key inside, before and at the end of the window
        cur = "R5";
        enable = 1'b1;
        run_to(3); kick_once(BADK);
        check("R5", "bad key in window", int'(cause), 3);
        clear_fault();
        enable = 1'b1;
        run_to(1); kick_once(BADK);
        check("R5", "bad key beats early", int'(cause), 3);
        clear_fault();
        enable = 1'b1;
        run_to(6); kick_once(BADK);
        check("R5", "bad key beats late", int'(cause), 3);
        clear_fault();

        // R10: kicks ignored while disabled, count restarts on enable
        cur = "R10";
        enable = 1'b1;
        run_to(5);
        enable = 1'b0;
        kick_once(BADK); kick_once(KEYV); step();
        check("R10", "no fault while disabled", int'(fault), 0);
        enable = 1'b1;
        step(); step();
        kick_once(KEYV);
        check("R10", "count restarted from zero", int'(fault), 0);

        summary();
        $finish;
    end

endmodule